// File: doc/BRIEF.md
# DAC Code Staging Register

This block is the digital side of a 10-bit digital-to-analog converter inside a microcontroller. Software reaches it over a byte-wide register bus: one control register and two data bytes. The block turns those byte writes into a 10-bit converter code. The code is either right-aligned, with two bits in the high byte, or left-aligned, with eight bits in the high byte so that 8-bit users write one byte. A low-byte write arms a lock that holds back every update of the converter input until the matching high byte arrives. This keeps a two-byte code from ever being seen half-written.

The staged code moves to the converter input in one of two ways. In manual mode it moves on the high-byte write itself. In auto mode it moves on the rising edge of one of eight peripheral event flags, picked by a 3-bit select field. The edge counts whether or not the peripheral's interrupt is enabled. Two further outputs carry the converter enable and the pad-drive enable to the analog macro.

Top module: `dac_code_stage`

## Requirements
- R1: After reset every register reads 0 and `dac_code`, `dac_on` and `pad_drive` are 0. Address 0 is control: bits 7:5 select, bit 3 auto mode, bit 2 left align, bit 1 pad drive, bit 0 enable, and bit 4 reads 0. Address 1 is the low byte, address 2 is the high byte, and address 3 reads 0.
- R2: With left align 0, the code formed is {high[1:0], low[7:0]}, and a read of the high byte returns only bits 1:0 with the rest 0.
- R3: With left align 1, the code formed is {high[7:0], low[7:6]}, and a read of the low byte returns only bits 7:6 with the rest 0.
- R4: A low-byte write blocks every update of `dac_code`, manual or triggered, from that cycle until a high-byte write clears the lock.
- R5: With enable 1 and auto 0, a high-byte write sets `dac_code` at the next clock edge.
- R6: Writing the align bit leaves `dac_code` unchanged. The new alignment applies from the next high-byte write on.
- R7: With enable 1 and auto 1, a high-byte write only stages the code. The staged code reaches `dac_code` at the clock edge in which the selected flag is 1 and was 0 at the previous edge. Select codes 0 to 7 map to flag inputs 0 to 7.
- R8: Rising edges on flags other than the selected one leave `dac_code` unchanged.
- R9: With enable 0, `dac_code` holds its value. High-byte writes still stage a code.
- R10: `dac_on` equals the enable bit, and `pad_drive` is 1 only when both the pad-drive bit and the enable bit are 1.
- R11: When a high-byte write and a selected rising edge fall in the same cycle, the newly written code is applied. When a low-byte write and a selected rising edge fall in the same cycle, no update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| evt_flags | input | 8 | Peripheral event flags |
| dac_code | output | 10 | Code driven to the converter |
| dac_on | output | 1 | Converter enable |
| pad_drive | output | 1 | Drive converter output to the pad |

## Verification
In auto mode, a bus write to a data byte and a rising edge of the selected flag can land in the same clock cycle. The bench forces both pairings by driving the flag from 0 to 1 in the very cycle of a high-byte write, and again in the very cycle of a low-byte write. In the first case the freshly written code must appear. In the second the converter code must stay put, because the lock wins. A behavioural model steps every clock and judges both outcomes along with all other traffic.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] A_HIGH = 2'd2;

  typedef struct packed {
    logic [2:0] sel;
    logic       auto_trig;
    logic       left;
    logic       pad_en;
    logic       conv_en;
  } ctrl_t;

  function automatic logic [CODE_W-1:0] compose(input logic left,
                                                input logic [BYTE_W-1:0] hi,
                                                input logic [BYTE_W-1:0] lo);
    if (left) compose = {hi, lo[7:6]};
    else      compose = {hi[1:0], lo};
  endfunction
endpackage

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output ctrl_t             ctrl_q,
  output logic [BYTE_W-1:0] low_q,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic              lock_q
);
  ctrl_t             ctrl_d;
  logic [BYTE_W-1:0] low_d, high_q, high_d;
  logic              lock_d, ctrl_wr;

  assign ctrl_wr = we && (addr == A_CTRL);
  assign lo_wr   = we && (addr == A_LOW);
  assign hi_wr   = we && (addr == A_HIGH);

  always_comb begin
    ctrl_d = ctrl_q;
    low_d  = low_q;
    high_d = high_q;
    lock_d = lock_q;
    if (ctrl_wr) ctrl_d = '{sel: wdata[7:5], auto_trig: wdata[3], left: wdata[2],
                            pad_en: wdata[1], conv_en: wdata[0]};
    if (lo_wr) begin
      low_d  = wdata;
      lock_d = 1'b1;
    end
    if (hi_wr) begin
      high_d = wdata;
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      low_q  <= '0;
      high_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      low_q  <= low_d;
      high_q <= high_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = {ctrl_q.sel, 1'b0, ctrl_q.auto_trig, ctrl_q.left,
                       ctrl_q.pad_en, ctrl_q.conv_en};
      A_LOW:  rdata = ctrl_q.left ? {low_q[7:6], 6'b0} : low_q;
      A_HIGH: rdata = ctrl_q.left ? high_q : {6'b0, high_q[1:0]};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dac_edge_pick.sv
module dac_edge_pick #(
  parameter int N_EVT = 8,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] flags,
  input  logic [SEL_W-1:0] sel,
  output logic             rise
);
  logic [N_EVT-1:0] prev_q, edge_v;

  genvar g;
  generate
    for (g = 0; g < N_EVT; g++) begin : g_edge
      assign edge_v[g] = flags[g] & ~prev_q[g];
    end
  endgenerate

  assign rise = edge_v[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= flags;
  end
endmodule

// File: rtl/dac_code_update.sv
module dac_code_update
  import dac_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic              lock_q,
  input  logic              rise,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] low_q,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] staged_q, staged_d, code_d, fresh;
  logic              blocked, trig_go;

  assign fresh   = compose(ctrl.left, wdata, low_q);
  assign blocked = lo_wr || (lock_q && !hi_wr);
  assign trig_go = ctrl.auto_trig && rise && !blocked;

  always_comb begin
    staged_d = hi_wr ? fresh : staged_q;
    code_d   = code_q;
    if (ctrl.conv_en) begin
      if (hi_wr && !ctrl.auto_trig) code_d = fresh;
      else if (trig_go)             code_d = staged_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      code_q   <= '0;
    end else begin
      staged_q <= staged_d;
      code_q   <= code_d;
    end
  end
endmodule

// File: rtl/dac_code_stage.sv
module dac_code_stage
  import dac_stage_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [N_EVT-1:0]  evt_flags,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_on,
  output logic              pad_drive
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] low_q;
  logic              lo_wr, hi_wr, lock_q, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  dac_regbank u_regs (
    .clk(clk), .rst_n(rst_sn), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .ctrl_q(ctrl_q), .low_q(low_q), .lo_wr(lo_wr),
    .hi_wr(hi_wr), .lock_q(lock_q)
  );

  dac_edge_pick #(.N_EVT(N_EVT)) u_edge (
    .clk(clk), .rst_n(rst_sn), .flags(evt_flags), .sel(ctrl_q.sel), .rise(rise)
  );

  dac_code_update u_upd (
    .clk(clk), .rst_n(rst_sn), .ctrl(ctrl_q), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .lock_q(lock_q), .rise(rise), .wdata(bus_wdata), .low_q(low_q),
    .code_q(dac_code)
  );

  assign dac_on    = ctrl_q.conv_en;
  assign pad_drive = ctrl_q.pad_en & ctrl_q.conv_en;
endmodule

// File: rtl/dac_code_stage_chk.sv
module dac_code_stage_chk
  import dac_stage_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_on,
  input logic              pad_drive,
  input ctrl_t             ctrl,
  input logic [BYTE_W-1:0] low_q
);
  assert_ctrl_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[4] == 1'b0));

  assert_right_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HIGH && ctrl.conv_en && !ctrl.auto_trig && !ctrl.left)
    |=> (dac_code == {$past(bus_wdata[1:0]), $past(low_q)}));

  assert_left_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HIGH && ctrl.conv_en && !ctrl.auto_trig && ctrl.left)
    |=> (dac_code == {$past(bus_wdata), $past(low_q[7:6])}));

  assert_low_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOW) |=> $stable(dac_code));

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_on |=> $stable(dac_code));

  assert_pad_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pad_drive |-> dac_on);
endmodule

bind dac_code_stage dac_code_stage_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_code(dac_code),
  .dac_on(dac_on), .pad_drive(pad_drive), .ctrl(ctrl_q), .low_q(low_q)
);

// File: tb/dac_code_stage_bench.sv
`timescale 1ns/1ps
module dac_code_stage_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata, bus_rdata, evt;
  logic [9:0] dac_code;
  logic       dac_on, pad_drive;

  integer total = 0, bad = 0;
  bit     done = 0;
  logic [7:0] fl = 8'h00;

  // behavioural reference state
  integer m_ctrl = 0, m_low = 0, m_high = 0, m_staged = 0, m_code = 0, m_prev = 0;
  bit     m_lock = 0;

  always #10 clk = ~clk;

  dac_code_stage u_dac_code_stage (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_flags(evt),
    .dac_code(dac_code), .dac_on(dac_on), .pad_drive(pad_drive)
  );

  function automatic integer m_read(input integer a);
    bit left = m_ctrl[2];
    case (a)
      0: m_read = m_ctrl;
      1: m_read = left ? (m_low & 8'hC0) : m_low;
      2: m_read = left ? m_high : (m_high & 8'h03);
      default: m_read = 0;
    endcase
  endfunction

  task automatic chk(input integer act, input integer exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input integer a, input bit w, input integer d, input integer f);
    bit lo = w && a == 1, hi = w && a == 2, cw = w && a == 0;
    integer sel = (m_ctrl >> 5) & 7;
    bit en = m_ctrl[0], auto_m = m_ctrl[3], left = m_ctrl[2];
    bit rise = f[sel] && !m_prev[sel];
    integer fresh = left ? ((d << 2) | ((m_low >> 6) & 3)) : (((d & 3) << 8) | m_low);
    if (en) begin
      if (hi && !auto_m) m_code = fresh;
      else if (auto_m && rise && !lo && (!m_lock || hi)) m_code = hi ? fresh : m_staged;
    end
    if (hi) begin m_staged = fresh; m_high = d; m_lock = 0; end
    if (lo) begin m_low = d; m_lock = 1; end
    if (cw) m_ctrl = d & 8'hEF;
    m_prev = f;
  endtask

  task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d, input string tag);
    bus_addr = a; bus_we = w; bus_wdata = d; evt = fl;
    #1;
    chk(bus_rdata, m_read(a), tag, "rdata");
    @(posedge clk);
    model(a, w, d, fl);
    @(negedge clk);
    chk(dac_code, m_code, tag, "dac_code");
    chk(dac_on, m_ctrl[0], "R10", "dac_on");
    chk(pad_drive, m_ctrl[1] & m_ctrl[0], "R10", "pad_drive");
  endtask

  task automatic idle(input string tag);
    step(2'd0, 1'b0, 8'h00, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(a, 1'b1, d, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 0; bus_we = 0; bus_wdata = 0; evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state on every address
    chk(dac_code, 0, "R1", "reset code");
    for (int i = 0; i < 4; i++) step(i[1:0], 1'b0, 8'h00, "R1");
    wr(2'd0, 8'hFF, "R1");          // bit4 must read 0 afterwards
    idle("R1");
    wr(2'd0, 8'h01, "R5");          // enable, right, manual
    // R2 / R5 right alignment
    wr(2'd1, 8'hA5, "R4");
    idle("R4");
    wr(2'd2, 8'hFF, "R2");
    step(2'd2, 1'b0, 8'h00, "R2");  // high reads 0x03
    wr(2'd1, 8'h11, "R4");
    idle("R4"); idle("R4");
    wr(2'd2, 8'h02, "R5");
    // R6 alignment switch leaves code, then R3
    wr(2'd0, 8'h05, "R6");
    idle("R6");
    step(2'd1, 1'b0, 8'h00, "R3");  // low reads bits 7:6 only
    wr(2'd2, 8'h80, "R3");
    wr(2'd1, 8'hC0, "R3");
    wr(2'd2, 8'h12, "R3");
    // R7 auto mode, select 3, right align
    wr(2'd0, 8'h69, "R7");
    wr(2'd1, 8'h55, "R7");
    wr(2'd2, 8'h01, "R7");
    idle("R7");
    fl = 8'h04; idle("R8");         // non-selected flag edge
    fl = 8'h00; idle("R8");
    fl = 8'h08; idle("R7");         // selected edge applies staged code
    idle("R7");
    fl = 8'h00; idle("R7");
    wr(2'd2, 8'h03, "R7");
    wr(2'd1, 8'h77, "R4");
    fl = 8'h08; idle("R4");         // blocked by lock
    fl = 8'h00; idle("R4");
    fl = 8'h08; wr(2'd2, 8'h02, "R11"); // high write with edge
    fl = 8'h00; idle("R11");
    fl = 8'h08; wr(2'd1, 8'h99, "R11"); // low write with edge
    fl = 8'h00; wr(2'd2, 8'h01, "R11");
    fl = 8'h08; idle("R11");
    fl = 8'h00;
    // R7 another select code (7) and left mode
    wr(2'd0, 8'hED, "R7");
    wr(2'd2, 8'h3C, "R7");
    fl = 8'h80; idle("R7");
    fl = 8'h00; idle("R7");
    // R9 disabled holds
    wr(2'd0, 8'h02, "R9");
    wr(2'd2, 8'h01, "R9");
    wr(2'd1, 8'h44, "R9");
    wr(2'd2, 8'h03, "R9");
    idle("R9");
    // R10 pad gating
    wr(2'd0, 8'h03, "R10");
    wr(2'd2, 8'h02, "R10");
    wr(2'd0, 8'h02, "R10");
    wr(2'd0, 8'h00, "R10");
    idle("R10");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule